// File: doc/BRIEF.md
# Interrupt Controller with Idle Wake

This block collects level-sensitive interrupt requests from up to `NSRC` peripherals and turns them into two core request lines: a normal line and a fast line. Each source has a mask bit and a level bit. An unmasked source with its level bit at 0 drives the normal line. An unmasked source with its level bit at 1 drives the fast line. Both lines are registered. Alongside them the block presents a vector offset and the index of the lowest-numbered source in whichever view is being signalled.

The block also keeps an idle flag. An idle-enter input sets the flag. A qualifying pending source clears it and produces a one-cycle wake pulse. A control bit chooses whether wake-up uses the raw pending sources or only the unmasked ones. A wake caused by a masked source never produces a core request or a vector: the request lines follow only the masked views.

Software reaches the mask, level and control registers, and three read-only pending views, through a single address port that has a write strobe and a combinational read path.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, all registers, `irq_o`, `fiq_o`, `vec_o`, `idx_o`, `idle_o` and `wake_o` are zero, and every readable address returns zero while the sources are low.
- R2: Address 3 reads the raw pending word, which equals `src_i` in every bit whatever the mask holds.
- R3: Address 4 reads raw AND mask AND NOT level. Address 5 reads raw AND mask AND level.
- R4: `irq_o` is the OR of the address-4 view and `fiq_o` is the OR of the address-5 view, each taken one clock edge after the inputs change.
- R5: `vec_o` is 0x1C when `fiq_o` is high, 0x18 when only `irq_o` is high, and 0 otherwise, updated on the same edge as the lines. The fast line wins when both are active.
- R6: `idx_o` gives the lowest set bit of the address-5 view if that view is non-zero, otherwise the lowest set bit of the address-4 view, otherwise 0. It is updated on the same edge as the lines.
- R7: A write at address 0 (mask), 1 (level) or 2 (control) changes that register on the next edge and is visible on read from then on. Only bit 0 of the control register is stored. Writes to addresses 3 to 7 change nothing.
- R8: With the block not idle, a high `idle_enter_i` sets `idle_o` on the next edge. A wake pulse only follows a cycle in which `idle_o` was high.
- R9: With control bit 0 at 0, any raw pending source wakes the block from idle, even when the mask is all zeros.
- R10: With control bit 0 at 1, only a source that is both pending and unmasked wakes the block. Masked sources leave it idle.
- R11: A wake clears `idle_o` and raises `wake_o` for exactly one cycle, both on the same edge.
- R12: When both masked views are empty, `irq_o` and `fiq_o` stay low and `vec_o` stays 0, including the cycles right after a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NSRC | Level-sensitive source requests |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NSRC | Write data |
| rd_data_o | output | NSRC | Read data for `addr_i` (combinational) |
| idle_enter_i | input | 1 | Request to enter idle |
| idle_o | output | 1 | Idle flag |
| wake_o | output | 1 | One-cycle wake pulse |
| irq_o | output | 1 | Normal core request |
| fiq_o | output | 1 | Fast core request |
| vec_o | output | 5 | Vector offset (0x18, 0x1C or 0) |
| idx_o | output | IDXW | Lowest active source in the signalled view |

## Verification
The bench builds the block with `NSRC` = 8, so every one of the 256 source words can be applied under each of several mask and level patterns. This reaches every combination of split views, lowest-index selection and fast-over-normal priority. The idle sequences use the same small width to show a wake from a masked source with the control bit clear, the lack of one with the bit set, and silent request lines after such a wake.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam logic [2:0] A_MASK  = 3'd0;
  localparam logic [2:0] A_LEVEL = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_RAW   = 3'd3;
  localparam logic [2:0] A_IRQV  = 3'd4;
  localparam logic [2:0] A_FIQV  = 3'd5;

  localparam logic [4:0] VEC_NONE = 5'h00;
  localparam logic [4:0] VEC_IRQ  = 5'h18;
  localparam logic [4:0] VEC_FIQ  = 5'h1C;
endpackage

// File: rtl/irqw_regs.sv
module irqw_regs
  import irqw_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] irqv,
  input  logic [NSRC-1:0] fiqv,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] level_q,
  output logic            ctrl_q,
  output logic [NSRC-1:0] rdata
);
  logic [NSRC-1:0] mask_d, level_d;
  logic            ctrl_d;
  logic            mask_we, level_we, ctrl_we;

  always_comb begin
    mask_we  = wr_en && (addr == A_MASK);
    level_we = wr_en && (addr == A_LEVEL);
    ctrl_we  = wr_en && (addr == A_CTRL);
    mask_d   = mask_we  ? wdata    : mask_q;
    level_d  = level_we ? wdata    : level_q;
    ctrl_d   = ctrl_we  ? wdata[0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      level_q <= '0;
      ctrl_q  <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      level_q <= level_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_MASK:  rdata = mask_q;
      A_LEVEL: rdata = level_q;
      A_CTRL:  rdata = {{(NSRC-1){1'b0}}, ctrl_q};
      A_RAW:   rdata = raw;
      A_IRQV:  rdata = irqv;
      A_FIQV:  rdata = fiqv;
      default: rdata = '0;
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> (ctrl_q == $past(wdata[0]))); // R7
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_CTRL) |=> ($stable(mask_q) && $stable(level_q) && $stable(ctrl_q))); // R7
endmodule

// File: rtl/irqw_route.sv
module irqw_route
  import irqw_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] level,
  output logic [NSRC-1:0] irqv,
  output logic [NSRC-1:0] fiqv,
  output logic            irq_q,
  output logic            fiq_q,
  output logic [4:0]      vec_q,
  output logic [IDXW-1:0] idx_q
);
  logic [NSRC-1:0] live, sel;
  logic            any_irq, any_fiq;
  logic [4:0]      vec_d;
  logic [IDXW-1:0] idx_d;

  always_comb begin
    live    = raw & mask;
    irqv    = live & ~level;
    fiqv    = live & level;
    any_irq = |irqv;
    any_fiq = |fiqv;
    sel     = any_fiq ? fiqv : irqv;
    idx_d   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (sel[i]) idx_d = IDXW'(i);
    end
    if (any_fiq)      vec_d = VEC_FIQ;
    else if (any_irq) vec_d = VEC_IRQ;
    else              vec_d = VEC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      vec_q <= VEC_NONE;
      idx_q <= '0;
    end else begin
      irq_q <= any_irq;
      fiq_q <= any_fiq;
      vec_q <= vec_d;
      idx_q <= idx_d;
    end
  end

  AST_FIQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_q |-> (vec_q == VEC_FIQ)); // R5
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !fiq_q) |-> (vec_q == VEC_IRQ)); // R5
  AST_QUIET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !fiq_q) |-> (vec_q == VEC_NONE && idx_q == '0)); // R12
  AST_REQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q || fiq_q) |-> $past(|(raw & mask))); // R12
endmodule

// File: rtl/irqw_idle.sv
module irqw_idle #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] mask,
  input  logic            use_mask,
  input  logic            enter,
  output logic            idle_q,
  output logic            wake_q
);
  logic wake_src, wake_now, idle_d;

  always_comb begin
    wake_src = use_mask ? |(raw & mask) : |raw;
    wake_now = idle_q && wake_src;
    if (wake_now)   idle_d = 1'b0;
    else if (enter) idle_d = 1'b1;
    else            idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      wake_q <= wake_now;
    end
  end

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q); // R11
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !idle_q); // R11
  AST_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(idle_q)); // R8
  AST_MASKED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && $past(use_mask)) |-> $past(|(raw & mask))); // R10
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int  NSRC = 32,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [2:0]      addr_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] rd_data_o,
  input  logic            idle_enter_i,
  output logic            idle_o,
  output logic            wake_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic [4:0]      vec_o,
  output logic [IDXW-1:0] idx_o
);
  logic [1:0]      rs_q;
  logic            rst_sn;
  logic [NSRC-1:0] mask, level, irqv, fiqv;
  logic            ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  irqw_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wr_data_i), .raw(src_i), .irqv(irqv), .fiqv(fiqv),
    .mask_q(mask), .level_q(level), .ctrl_q(ctrl), .rdata(rd_data_o)
  );

  irqw_route #(.NSRC(NSRC), .IDXW(IDXW)) u_route (
    .clk(clk), .rst_n(rst_sn), .raw(src_i), .mask(mask), .level(level),
    .irqv(irqv), .fiqv(fiqv), .irq_q(irq_o), .fiq_q(fiq_o),
    .vec_q(vec_o), .idx_q(idx_o)
  );

  irqw_idle #(.NSRC(NSRC)) u_idle (
    .clk(clk), .rst_n(rst_sn), .raw(src_i), .mask(mask), .use_mask(ctrl),
    .enter(idle_enter_i), .idle_q(idle_o), .wake_q(wake_o)
  );
endmodule

// File: tb/irq_wake_ctrl_test.sv
module irq_wake_ctrl_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [2:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          idle_enter = 1'b0;
  logic          idle, wake, irq, fiq;
  logic [4:0]    vec;
  logic [IW-1:0] idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_wake_ctrl #(.NSRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .idle_enter_i(idle_enter),
    .idle_o(idle), .wake_o(wake), .irq_o(irq), .fiq_o(fiq),
    .vec_o(vec), .idx_o(idx)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mpat [4];
    logic [7:0] lpat [4];
    mpat = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    lpat = '{8'h00, 8'hFF, 8'h0F, 8'h96};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 irq", irq, 0); chk("R1 fiq", fiq, 0); chk("R1 vec", vec, 0);
    chk("R1 idx", idx, 0); chk("R1 idle", idle, 0); chk("R1 wake", wake, 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 read", 3'(a), '0);

    // R7: register writes, control width, read-only addresses
    wr(3'd0, 8'h5A); rd_chk("R7 mask", 3'd0, 8'h5A);
    wr(3'd1, 8'hC3); rd_chk("R7 level", 3'd1, 8'hC3);
    wr(3'd2, 8'hFF); rd_chk("R7 ctrl bit0 only", 3'd2, 8'h01);
    for (int a = 3; a < 8; a++) wr(3'(a), 8'hFF);
    rd_chk("R7 mask kept", 3'd0, 8'h5A);
    rd_chk("R7 level kept", 3'd1, 8'hC3);
    rd_chk("R7 ctrl kept", 3'd2, 8'h01);
    wr(3'd2, 8'h00);

    // R2..R6: sweep of every source word under several masks and levels
    for (int mi = 0; mi < 4; mi++) begin
      for (int li = 0; li < 4; li++) begin
        wr(3'd0, mpat[mi]);
        wr(3'd1, lpat[li]);
        for (int s = 0; s < 256; s++) begin
          logic [N-1:0] ev_i, ev_f;
          logic [4:0] ev;
          int ex;
          @(negedge clk);
          src = 8'(s);
          ev_i = 8'(s) & mpat[mi] & ~lpat[li];
          ev_f = 8'(s) & mpat[mi] & lpat[li];
          rd_chk("R2 raw", 3'd3, 8'(s));
          rd_chk("R3 irq view", 3'd4, ev_i);
          rd_chk("R3 fiq view", 3'd5, ev_f);
          ev = (ev_f != 0) ? 5'h1C : (ev_i != 0) ? 5'h18 : 5'h00;
          ex = (ev_f != 0) ? lowest(ev_f) : lowest(ev_i);
          @(negedge clk);
          chk("R4 irq", irq, (ev_i != 0));
          chk("R4 fiq", fiq, (ev_f != 0));
          chk("R5 vec", vec, ev);
          chk("R6 idx", idx, ex);
          if (ev_i == 0 && ev_f == 0) chk("R12 quiet", {irq, fiq}, 0);
        end
      end
    end
    @(negedge clk); src = '0;

    // R8, R9, R11, R12: wake through a masked source with control bit clear
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    @(negedge clk); idle_enter = 1'b1;
    @(negedge clk); idle_enter = 1'b0;
    chk("R8 idle set", idle, 1); chk("R8 no wake", wake, 0);
    src = 8'h04;
    @(negedge clk);
    chk("R9 wake", wake, 1); chk("R11 idle cleared", idle, 0);
    chk("R12 no irq", irq, 0); chk("R12 no fiq", fiq, 0); chk("R12 no vec", vec, 0);
    @(negedge clk);
    chk("R11 one cycle", wake, 0);
    chk("R12 still no irq", irq, 0); chk("R12 still no fiq", fiq, 0);
    src = '0;

    // R10: control bit set, masked source leaves block idle
    wr(3'd0, 8'h01); wr(3'd1, 8'h01); wr(3'd2, 8'h01);
    @(negedge clk); idle_enter = 1'b1;
    @(negedge clk); idle_enter = 1'b0;
    src = 8'h04;
    @(negedge clk);
    chk("R10 masked no wake", wake, 0); chk("R10 still idle", idle, 1);
    @(negedge clk);
    chk("R10 masked no wake later", wake, 0);
    src = 8'h05;
    @(negedge clk);
    chk("R10 unmasked wake", wake, 1); chk("R11 idle cleared", idle, 0);
    chk("R5 fiq with wake", fiq, 1); chk("R5 fiq vec", vec, 5'h1C);
    @(negedge clk);
    chk("R11 one cycle", wake, 0);
    src = '0;

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule